// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block is a byte-wide register bank for a fan-controller style device. A host reaches it through a plain strobe port with an 8-bit address and 8-bit data. Reset loads every register with its default. The bank holds the following registers:

- a writable configuration register;
- a per-source alert mask register;
- a read-only view of the live status inputs;
- a features register and three identification registers, all read-only;
- a lock register.

Setting the lock freezes the configuration and mask registers until the next reset. The block turns the status inputs into one active-low alert. Each source can be masked on its own, and a global mask bit in the configuration register can suppress the alert entirely. Two configuration bits go out as plain control levels: one disables the bus timeout and one selects continuous watchdog operation. Logic elsewhere acts on them.

Register addresses (hex): configuration 20h, alert mask 28h, status view 24h, lock EFh, features FCh, identification FDh/FEh/FFh. Every other address is undefined.

Top module: `lockable_cfg_regs`

## Requirements
- R1: After reset the configuration register reads 40h, the alert mask 00h and the lock register 00h, and rdata is 00h.
- R2: A read of any undefined address returns 00h.
- R3: A write to any undefined address changes no register: the configuration, mask and lock registers keep their values.
- R4: FCh reads 00h, FDh reads 34h, FEh reads 5Dh and FFh reads 80h, before and after any write to them.
- R5: While unlocked, a write to 20h stores data bits 7:5, and bits 4:0 of that register always read 0.
- R6: While the lock bit is set, writes to 20h and to 28h are ignored.
- R7: Bit 0 of EFh is the lock bit, and writing a 1 to it sets it. Once set it stays set until reset, even when 0 is written to it. Bits 7:1 of EFh read 0.
- R8: While configuration bit 7 is 0, alert_n is 0 exactly when some status bit i is 1 while mask bit i is 0 (mask bit 1 = source masked). alert_n follows the inputs combinationally.
- R9: While configuration bit 7 is 1, alert_n is 1 whatever the status and mask bits are.
- R10: timeout_dis equals configuration bit 6 and wdog_cont equals configuration bit 5.
- R11: Read data is registered. It shows the addressed register in the cycle after the clock edge that samples rd_en, and holds its value when rd_en is low.
- R12: While unlocked, 28h stores the written byte. 24h reads the current status inputs and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| status_i | input | NUM_SRC (8) | Status event bits |
| alert_n | output | 1 | Active-low alert |
| timeout_dis | output | 1 | Bus timeout disable control |
| wdog_cont | output | 1 | Continuous watchdog enable control |

## Verification
The bench builds the block with its default widths: 8 address bits, 8 data bits and 8 status sources. With these widths the whole 256-entry address space can be swept for reads before and after writes to every address. The sweep covers all three lock situations. The alert logic gets every one of the 256 status patterns against several mask patterns, with the global mask at both values. The expected alert level comes from bitwise arithmetic in the bench.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_CFG  = 8'h20;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h24;
    localparam logic [ADDR_W-1:0] A_MASK = 8'h28;
    localparam logic [ADDR_W-1:0] A_LOCK = 8'hEF;
    localparam logic [ADDR_W-1:0] A_FEAT = 8'hFC;
    localparam logic [ADDR_W-1:0] A_PID  = 8'hFD;
    localparam logic [ADDR_W-1:0] A_MID  = 8'hFE;
    localparam logic [ADDR_W-1:0] A_REV  = 8'hFF;

    localparam logic [DATA_W-1:0] CFG_RST  = 8'h40;
    localparam logic [DATA_W-1:0] FEAT_VAL = 8'h00;
    localparam logic [DATA_W-1:0] PID_VAL  = 8'h34;
    localparam logic [DATA_W-1:0] MID_VAL  = 8'h5D;
    localparam logic [DATA_W-1:0] REV_VAL  = 8'h80;

    // number of stored configuration bits (7:5)
    localparam int CFG_KEEP = 3;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_STAT,
        SEL_MASK,
        SEL_LOCK,
        SEL_FEAT,
        SEL_PID,
        SEL_MID,
        SEL_REV
    } reg_sel_e;
endpackage

// File: rtl/rb_addr_decode.sv
module rb_addr_decode
    import regbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              lockable
);
    always_comb begin
        unique case (addr)
            A_CFG:   sel = SEL_CFG;
            A_STAT:  sel = SEL_STAT;
            A_MASK:  sel = SEL_MASK;
            A_LOCK:  sel = SEL_LOCK;
            A_FEAT:  sel = SEL_FEAT;
            A_PID:   sel = SEL_PID;
            A_MID:   sel = SEL_MID;
            A_REV:   sel = SEL_REV;
            default: sel = SEL_NONE;
        endcase
        lockable = (sel == SEL_CFG) || (sel == SEL_MASK);
    end
endmodule

// File: rtl/rb_alert_combine.sv
module rb_alert_combine #(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic               global_mask,
    output logic               alert_n
);
    logic [NUM_SRC-1:0] live;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
            assign live[gi] = status_i[gi] & ~mask_i[gi];
        end
    endgenerate

    always_comb begin
        alert_n = global_mask | ~(|live);
    end
endmodule

// File: rtl/lockable_cfg_regs.sv
module lockable_cfg_regs
    import regbank_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [7:0]         addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic [NUM_SRC-1:0] status_i,
    output logic               alert_n,
    output logic               timeout_dis,
    output logic               wdog_cont
);
    localparam int CFG_LO = DATA_W - CFG_KEEP;

    typedef struct packed {
        logic [CFG_KEEP-1:0] cfg;
        logic [NUM_SRC-1:0]  mask;
        logic                lock;
        logic [DATA_W-1:0]   rdata;
    } state_t;

    state_t   st_d, st_q;
    reg_sel_e sel;
    logic     lockable;
    logic     wr_block;
    logic [DATA_W-1:0] rd_word;

    rb_addr_decode i_dec (
        .addr     (addr),
        .sel      (sel),
        .lockable (lockable)
    );

    rb_alert_combine #(.NUM_SRC(NUM_SRC)) i_alert (
        .status_i    (status_i),
        .mask_i      (st_q.mask),
        .global_mask (st_q.cfg[CFG_KEEP-1]),
        .alert_n     (alert_n)
    );

    always_comb begin
        unique case (sel)
            SEL_CFG:  rd_word = {st_q.cfg, {CFG_LO{1'b0}}};
            SEL_STAT: rd_word = DATA_W'(status_i);
            SEL_MASK: rd_word = DATA_W'(st_q.mask);
            SEL_LOCK: rd_word = DATA_W'(st_q.lock);
            SEL_FEAT: rd_word = FEAT_VAL;
            SEL_PID:  rd_word = PID_VAL;
            SEL_MID:  rd_word = MID_VAL;
            SEL_REV:  rd_word = REV_VAL;
            default:  rd_word = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        wr_block = lockable && st_q.lock;
        if (wr_en && !wr_block) begin
            unique case (sel)
                SEL_CFG:  st_d.cfg  = wdata[DATA_W-1:CFG_LO];
                SEL_MASK: st_d.mask = wdata[NUM_SRC-1:0];
                SEL_LOCK: st_d.lock = st_q.lock | wdata[0];
                default:  ;
            endcase
        end
        if (rd_en) begin
            st_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg   <= CFG_RST[DATA_W-1:CFG_LO];
            st_q.mask  <= '0;
            st_q.lock  <= 1'b0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata       = st_q.rdata;
    assign timeout_dis = st_q.cfg[CFG_KEEP-2];
    assign wdog_cont   = st_q.cfg[CFG_KEEP-3];

    // R6
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock && wr_en && (addr == A_CFG || addr == A_MASK))
        |=> ($stable(st_q.cfg) && $stable(st_q.mask)));

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock);

    // R9
    glob_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg[CFG_KEEP-1] |-> alert_n);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R4
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_PID) |=> (rdata == 8'h34));

    // R2
    undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> (rdata == 8'h00));
endmodule

// File: tb/test_lockable_cfg_regs.sv
module test_lockable_cfg_regs;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] status_i = 8'h00;
    logic       alert_n;
    logic       timeout_dis;
    logic       wdog_cont;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    lockable_cfg_regs i_lockable_cfg_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .status_i(status_i),
        .alert_n(alert_n), .timeout_dis(timeout_dis), .wdog_cont(wdog_cont)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic bit is_defined(input logic [7:0] a);
        return a == 8'h20 || a == 8'h24 || a == 8'h28 || a == 8'hEF ||
               a >= 8'hFC;
    endfunction

    function automatic logic [7:0] id_value(input logic [7:0] a);
        case (a)
            8'hFD:   return 8'h34;
            8'hFE:   return 8'h5D;
            8'hFF:   return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic check_regs(input string req, input logic [7:0] cfg_e,
                              input logic [7:0] mask_e, input logic [7:0] lock_e);
        logic [7:0] v;
        do_read(8'h20, v); check(req, v, cfg_e);
        do_read(8'h28, v); check(req, v, mask_e);
        do_read(8'hEF, v); check(req, v, lock_e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", rdata, 8'h00);
        check("R10 timeout_dis", {7'd0, timeout_dis}, 8'h01);
        check("R10 wdog_cont", {7'd0, wdog_cont}, 8'h00);
        check_regs("R1", 8'h40, 8'h00, 8'h00);

        // R2, R4 full read sweep
        for (int a = 0; a < 256; a++) begin
            if (!is_defined(8'(a))) begin
                do_read(8'(a), v); check("R2", v, 8'h00);
            end else if (a >= 8'hFC) begin
                do_read(8'(a), v); check("R4", v, id_value(8'(a)));
            end
        end

        // R11 hold when rd_en is low
        do_read(8'hFE, v);
        @(negedge clk); addr = 8'h20;
        repeat (3) @(negedge clk);
        check("R11 hold", rdata, 8'h5D);

        // R3 writes to every undefined address, R4 writes to id regs
        for (int a = 0; a < 256; a++) begin
            if (!is_defined(8'(a)) || a >= 8'hFC) begin
                do_write(8'(a), 8'hFF);
                do_read(8'(a), v);
                if (a >= 8'hFC) check("R4 write", v, id_value(8'(a)));
                else            check("R2 after write", v, 8'h00);
            end
        end
        check_regs("R3", 8'h40, 8'h00, 8'h00);

        // R12 status view, ignores writes
        for (int s = 0; s < 256; s += 17) begin
            status_i = 8'(s);
            do_write(8'h24, 8'(~s));
            do_read(8'h24, v); check("R12 status", v, 8'(s));
        end
        status_i = 8'h00;

        // R5 / R10 cfg writes
        for (int d = 0; d < 256; d += 13) begin
            do_write(8'h20, 8'(d));
            do_read(8'h20, v); check("R5", v, 8'(d) & 8'hE0);
            check("R10 timeout_dis", {7'd0, timeout_dis}, {7'd0, v[6]});
            check("R10 wdog_cont", {7'd0, wdog_cont}, {7'd0, v[5]});
        end
        // R12 mask writes
        for (int d = 0; d < 256; d += 29) begin
            do_write(8'h28, 8'(d));
            do_read(8'h28, v); check("R12 mask", v, 8'(d));
        end

        // R8 / R9 alert sweep
        for (int g = 0; g < 2; g++) begin
            for (int m = 0; m < 4; m++) begin
                logic [7:0] mk;
                mk = (m == 0) ? 8'h00 : (m == 1) ? 8'hFF : (m == 2) ? 8'hA5 : 8'h3C;
                do_write(8'h20, g[0] ? 8'h80 : 8'h00);
                do_write(8'h28, mk);
                for (int s = 0; s < 256; s++) begin
                    logic exp_n;
                    @(negedge clk);
                    status_i = 8'(s);
                    #1;
                    exp_n = (g != 0) || ((8'(s) & ~mk) == 8'h00);
                    check(g != 0 ? "R9" : "R8", {7'd0, alert_n}, {7'd0, exp_n});
                end
            end
        end
        status_i = 8'h00;

        // R7 / R6 lock
        do_write(8'h20, 8'h20);
        do_write(8'h28, 8'h5A);
        do_write(8'hEF, 8'hFE);
        check_regs("R7 bit0 only", 8'h20, 8'h5A, 8'h00);
        do_write(8'hEF, 8'hFF);
        check_regs("R7 set", 8'h20, 8'h5A, 8'h01);
        do_write(8'h20, 8'hC0);
        do_write(8'h28, 8'h00);
        check_regs("R6 frozen", 8'h20, 8'h5A, 8'h01);
        check("R6 wdog_cont", {7'd0, wdog_cont}, 8'h01);
        do_write(8'hEF, 8'h00);
        check_regs("R7 sticky", 8'h20, 8'h5A, 8'h01);
        for (int a = 0; a < 256; a++) begin
            if (!is_defined(8'(a))) do_write(8'(a), 8'h00);
        end
        check_regs("R3 locked", 8'h20, 8'h5A, 8'h01);
        do_read(8'hFF, v); check("R4 locked", v, 8'h80);

        // R1 reset clears lock
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check_regs("R1 re-reset", 8'h40, 8'h00, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule